// File: doc/BRIEF.md
# Root-Port Interrupt Status Aggregator

This block gathers the interrupt events a root port sees: legacy INTx assert and deassert strobes for four lines, MSI writes carrying a 5-bit vector index and an 8-bit payload, and two housekeeping event strobes (link power-state change and flush). Each event lands in a sticky status bit. Software clears a status bit by writing 1 to it. Each status register has a mask register with the same bit layout, and a mask bit of 1 blocks that source from reaching the next level.

The status is held in three levels. The 32 per-vector MSI bits feed one MSI-pending bit in the primary register, which also holds the INTx bits. The primary and secondary registers feed one core bit in the host register. The output `irq_out` is a level signal that stays high while any unmasked host bit is set. Software clears the lower levels first and clears the host core bit last. If a lower source is still pending when software clears the core bit, the core bit sets again.

Top module: `irq_root_aggregator`

## Requirements
- R1: A pulse on INTx assert line n (n = 0..3) sets primary status bit 16+n. A pulse on INTx deassert line n sets primary status bit 20+n.
- R2: An MSI arrival with vector index v sets MSI status bit v whatever the MSI mask holds. The payload register (index 6) then returns the 8-bit payload of the most recent arrival in bits 7:0, and bits 31:8 read 0.
- R3: An MSI arrival whose vector is unmasked (MSI mask bit v = 0) sets primary bit 24 on the same clock edge as the MSI status bit. An arrival whose vector is masked leaves primary bit 24 clear.
- R4: A power-state-change strobe sets secondary bit 4 and a flush strobe sets secondary bit 5. No other secondary status or mask bit can be set.
- R5: Every status register (primary 0, secondary 2, MSI 4, host 7) is write-1-to-clear. A written 1 clears that bit and a written 0 leaves it unchanged. Primary bits 26:0 exist and its other bits read 0.
- R6: When an event arrives in the same cycle as a write-1-to-clear of its bit, the bit stays set.
- R7: Each mask register holds the same layout as its status register (primary 1, secondary 3, MSI 5, host 8), and a 1 blocks that source. The reset values are 0x07FFFFFF, 0x00000030, 0xFFFFFFFF and 0x00FFF0FB. Only those bits can be written.
- R8: Host bit 16 sets one clock edge after any unmasked primary or secondary bit is set. While such a bit remains set, writing 1 to clear host bit 16 has no effect. Once the lower bits are cleared, the same write clears host bit 16.
- R9: `irq_out` is high in exactly the cycles where some host status bit is set and its host mask bit is 0.
- R10: After reset every status register reads 0 and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intx_assert | input | 4 | Per-line INTx assert strobes |
| intx_deassert | input | 4 | Per-line INTx deassert strobes |
| msi_valid | input | 1 | MSI arrival strobe |
| msi_vec | input | 5 | Vector index of the MSI |
| msi_data | input | 8 | Payload of the MSI |
| pwr_evt | input | 1 | Power-state change strobe |
| flush_evt | input | 1 | Flush event strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_out | output | 1 | Level summary interrupt |

## Verification
The hardest case to reach from the ports is an event and a clear of the same bit landing on one clock edge. The bench handles this by raising the INTx, MSI or secondary strobe in the same cycle as the register write, with no delay between them. The second hard case is a host-level clear while a lower source is still pending. To produce it, the bench clears the host core bit before and after clearing the primary bit and checks that only the second clear takes effect. Every INTx line in both directions and every MSI vector are swept, with payloads computed from the vector index.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef logic [31:0] word_t;

  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_PRI_STAT  = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRI_MASK  = 4'd1;
  localparam logic [ADDR_W-1:0] A_SEC_STAT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_SEC_MASK  = 4'd3;
  localparam logic [ADDR_W-1:0] A_MSI_STAT  = 4'd4;
  localparam logic [ADDR_W-1:0] A_MSI_MASK  = 4'd5;
  localparam logic [ADDR_W-1:0] A_MSI_DATA  = 4'd6;
  localparam logic [ADDR_W-1:0] A_HOST_STAT = 4'd7;
  localparam logic [ADDR_W-1:0] A_HOST_MASK = 4'd8;

  localparam int INTX_ON_LSB  = 16;
  localparam int INTX_OFF_LSB = 20;
  localparam int MSI_PEND_BIT = 24;
  localparam int SEC_PWR_BIT  = 4;
  localparam int SEC_FLUSH_BIT = 5;
  localparam int HOST_CORE_BIT = 16;

  localparam word_t PRI_IMPL  = 32'h07FF_FFFF;
  localparam word_t SEC_IMPL  = 32'h0000_0030;
  localparam word_t HOST_IMPL = 32'h00FF_F0FB;

  // next value of a sticky status word: clear first, new events win
  function automatic word_t w1c_next(word_t cur, word_t clr, word_t set, word_t impl);
    return ((cur & ~clr) | set) & impl;
  endfunction

  function automatic word_t pending(word_t stat, word_t mask);
    return stat & ~mask;
  endfunction
endpackage

// File: rtl/irq_w1c_reg.sv
module irq_w1c_reg
  import irq_agg_pkg::*;
#(
  parameter word_t IMPL = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  word_t clr_i,
  input  word_t set_i,
  output word_t q_o
);
  word_t q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= w1c_next(q, clr_i, set_i, IMPL);
  end

  assign q_o = q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & IMPL) != '0) |=> ((q_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));

  // R5
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i & IMPL) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_msi_bank.sv
module irq_msi_bank
  import irq_agg_pkg::*;
#(
  parameter int MSI_VECS = 32,
  parameter int PAY_W    = 8,
  localparam int VEC_W   = $clog2(MSI_VECS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msi_valid,
  input  logic [VEC_W-1:0] msi_vec,
  input  logic [PAY_W-1:0] msi_data,
  input  word_t            clr_i,
  input  word_t            mask_i,
  output word_t            stat_o,
  output logic [PAY_W-1:0] payload_o,
  output logic             hit_o
);
  localparam word_t MSI_IMPL = word_t'((64'd1 << MSI_VECS) - 64'd1);

  word_t            vec_set;
  logic [PAY_W-1:0] payload;

  assign vec_set = msi_valid ? (word_t'(1) << msi_vec) : '0;
  assign hit_o   = msi_valid && !mask_i[msi_vec];

  irq_w1c_reg #(.IMPL(MSI_IMPL)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .set_i(vec_set), .q_o(stat_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         payload <= '0;
    else if (msi_valid) payload <= msi_data;
  end

  assign payload_o = payload;

  // R2
  msi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid |=> (stat_o[$past(msi_vec)] && payload_o == $past(msi_data)));
endmodule

// File: rtl/irq_host_level.sv
module irq_host_level
  import irq_agg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t pri_stat,
  input  word_t pri_mask,
  input  word_t sec_stat,
  input  word_t sec_mask,
  input  word_t host_mask,
  input  word_t clr_i,
  output word_t host_stat,
  output logic  irq_o
);
  logic  core_evt;
  word_t host_set;

  assign core_evt = (pending(pri_stat, pri_mask) != '0) || (pending(sec_stat, sec_mask) != '0);
  assign host_set = word_t'(core_evt) << HOST_CORE_BIT;

  irq_w1c_reg #(.IMPL(HOST_IMPL)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .set_i(host_set), .q_o(host_stat)
  );

  assign irq_o = pending(host_stat, host_mask) != '0;

  // R8
  core_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_evt |=> host_stat[HOST_CORE_BIT]);
endmodule

// File: rtl/irq_root_aggregator.sv
module irq_root_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_INTX = 4,
  parameter int MSI_VECS = 32,
  parameter int PAY_W    = 8,
  localparam int VEC_W   = $clog2(MSI_VECS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_INTX-1:0] intx_assert,
  input  logic [NUM_INTX-1:0] intx_deassert,
  input  logic                msi_valid,
  input  logic [VEC_W-1:0]    msi_vec,
  input  logic [PAY_W-1:0]    msi_data,
  input  logic                pwr_evt,
  input  logic                flush_evt,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                irq_out
);
  localparam word_t MSI_IMPL = word_t'((64'd1 << MSI_VECS) - 64'd1);

  word_t pri_mask, sec_mask, msi_mask, host_mask;
  word_t pri_stat, sec_stat, msi_stat, host_stat;
  word_t pri_set, sec_set;
  word_t pri_clr, sec_clr, msi_clr, host_clr;
  logic [PAY_W-1:0] payload;
  logic  msi_hit;

  // write-1-to-clear strobes, one per status register
  assign pri_clr  = (reg_we && reg_addr == A_PRI_STAT)  ? reg_wdata : '0;
  assign sec_clr  = (reg_we && reg_addr == A_SEC_STAT)  ? reg_wdata : '0;
  assign msi_clr  = (reg_we && reg_addr == A_MSI_STAT)  ? reg_wdata : '0;
  assign host_clr = (reg_we && reg_addr == A_HOST_STAT) ? reg_wdata : '0;

  always_comb begin
    pri_set = '0;
    for (int i = 0; i < NUM_INTX; i++) begin
      pri_set[INTX_ON_LSB + i]  = intx_assert[i];
      pri_set[INTX_OFF_LSB + i] = intx_deassert[i];
    end
    pri_set[MSI_PEND_BIT] = msi_hit;
  end

  always_comb begin
    sec_set = '0;
    sec_set[SEC_PWR_BIT]   = pwr_evt;
    sec_set[SEC_FLUSH_BIT] = flush_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_mask  <= PRI_IMPL;
      sec_mask  <= SEC_IMPL;
      msi_mask  <= MSI_IMPL;
      host_mask <= HOST_IMPL;
    end else if (reg_we) begin
      case (reg_addr)
        A_PRI_MASK:  pri_mask  <= reg_wdata & PRI_IMPL;
        A_SEC_MASK:  sec_mask  <= reg_wdata & SEC_IMPL;
        A_MSI_MASK:  msi_mask  <= reg_wdata & MSI_IMPL;
        A_HOST_MASK: host_mask <= reg_wdata & HOST_IMPL;
        default: ;
      endcase
    end
  end

  irq_msi_bank #(.MSI_VECS(MSI_VECS), .PAY_W(PAY_W)) u_msi (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_vec(msi_vec),
    .msi_data(msi_data), .clr_i(msi_clr), .mask_i(msi_mask),
    .stat_o(msi_stat), .payload_o(payload), .hit_o(msi_hit)
  );

  irq_w1c_reg #(.IMPL(PRI_IMPL)) u_pri (
    .clk(clk), .rst_n(rst_n), .clr_i(pri_clr), .set_i(pri_set), .q_o(pri_stat)
  );

  irq_w1c_reg #(.IMPL(SEC_IMPL)) u_sec (
    .clk(clk), .rst_n(rst_n), .clr_i(sec_clr), .set_i(sec_set), .q_o(sec_stat)
  );

  irq_host_level u_host (
    .clk(clk), .rst_n(rst_n), .pri_stat(pri_stat), .pri_mask(pri_mask),
    .sec_stat(sec_stat), .sec_mask(sec_mask), .host_mask(host_mask),
    .clr_i(host_clr), .host_stat(host_stat), .irq_o(irq_out)
  );

  always_comb begin
    case (reg_addr)
      A_PRI_STAT:  reg_rdata = pri_stat;
      A_PRI_MASK:  reg_rdata = pri_mask;
      A_SEC_STAT:  reg_rdata = sec_stat;
      A_SEC_MASK:  reg_rdata = sec_mask;
      A_MSI_STAT:  reg_rdata = msi_stat;
      A_MSI_MASK:  reg_rdata = msi_mask;
      A_MSI_DATA:  reg_rdata = word_t'(payload);
      A_HOST_STAT: reg_rdata = host_stat;
      A_HOST_MASK: reg_rdata = host_mask;
      default:     reg_rdata = '0;
    endcase
  end

  // R3
  msi_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && !msi_mask[msi_vec]) |=> pri_stat[MSI_PEND_BIT]);
endmodule

// File: tb/sim_irq_root_aggregator.sv
`timescale 1ns/1ps
module sim_irq_root_aggregator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] intx_assert = '0, intx_deassert = '0;
  logic msi_valid = 1'b0;
  logic [4:0] msi_vec = '0;
  logic [7:0] msi_data = '0;
  logic pwr_evt = 1'b0, flush_evt = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_out;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_root_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .intx_assert(intx_assert), .intx_deassert(intx_deassert),
    .msi_valid(msi_valid), .msi_vec(msi_vec), .msi_data(msi_data),
    .pwr_evt(pwr_evt), .flush_evt(flush_evt), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // write lands at the next rising edge; returns at the following falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd7, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R10: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] exp_pay;
    idle(3);
    // R10 reset state
    chk_reg("R10 pri stat", 4'd0, 32'h0);
    chk_reg("R10 sec stat", 4'd2, 32'h0);
    chk_reg("R10 msi stat", 4'd4, 32'h0);
    chk_reg("R10 host stat", 4'd7, 32'h0);
    chk("R10 irq low", {31'b0, irq_out}, 32'h0);
    rst_n = 1'b1;
    idle(2);
    // R7 mask reset values
    chk_reg("R7 pri mask rst", 4'd1, 32'h07FF_FFFF);
    chk_reg("R7 sec mask rst", 4'd3, 32'h0000_0030);
    chk_reg("R7 msi mask rst", 4'd5, 32'hFFFF_FFFF);
    chk_reg("R7 host mask rst", 4'd8, 32'h00FF_F0FB);
    // R4 R7 writable bits only
    wr(4'd3, 32'hFFFF_FFCF);
    chk_reg("R4 sec mask impl", 4'd3, 32'h0);
    wr(4'd1, 32'hF800_0000);
    chk_reg("R7 pri mask impl", 4'd1, 32'h0);
    wr(4'd5, 32'h0);
    wr(4'd8, 32'hFFFF_FFFF & ~(32'h1 << 16));
    chk_reg("R7 host mask write", 4'd8, 32'h00FE_F0FB);

    // R1 R8 R9 INTx sweep, both directions
    for (int dir = 0; dir < 2; dir++) begin
      for (int n = 0; n < 4; n++) begin
        logic [31:0] bitv;
        bitv = 32'h1 << ((dir == 0 ? 16 : 20) + n);
        @(negedge clk);
        if (dir == 0) intx_assert[n] = 1'b1; else intx_deassert[n] = 1'b1;
        @(negedge clk);
        intx_assert = '0; intx_deassert = '0;
        chk_reg("R1 intx bit", 4'd0, bitv);
        chk_reg("R8 host not yet", 4'd7, 32'h0);
        @(negedge clk);
        chk_reg("R8 host core set", 4'd7, 32'h0001_0000);
        chk("R9 irq high", {31'b0, irq_out}, 32'h1);
        // R8 host clear ignored while lower pending
        wr(4'd7, 32'h0001_0000);
        chk_reg("R8 clear ignored", 4'd7, 32'h0001_0000);
        // R5 writing zeros leaves bits
        wr(4'd0, ~bitv);
        chk_reg("R5 zero write keeps", 4'd0, bitv);
        wr(4'd0, bitv);
        chk_reg("R5 w1c clears", 4'd0, 32'h0);
        wr(4'd7, 32'h0001_0000);
        chk_reg("R8 host clears", 4'd7, 32'h0);
        chk("R9 irq low", {31'b0, irq_out}, 32'h0);
      end
    end

    // R7 masked primary source does not reach host
    wr(4'd1, 32'h0000_0001 << 17);
    @(negedge clk); intx_assert[1] = 1'b1;
    @(negedge clk); intx_assert = '0;
    idle(2);
    chk_reg("R7 masked status set", 4'd0, 32'h0002_0000);
    chk_reg("R7 masked no host", 4'd7, 32'h0);
    chk("R7 masked irq low", {31'b0, irq_out}, 32'h0);
    clear_all();
    wr(4'd1, 32'h0);

    // R2 R3 MSI sweep over all vectors
    for (int v = 0; v < 32; v++) begin
      exp_pay = (v * 37 + 5) & 32'hFF;
      @(negedge clk);
      msi_valid = 1'b1; msi_vec = 5'(v); msi_data = exp_pay[7:0];
      @(negedge clk);
      msi_valid = 1'b0;
      chk_reg("R2 msi stat bit", 4'd4, 32'h1 << v);
      chk_reg("R2 payload", 4'd6, exp_pay);
      chk_reg("R3 msi pending", 4'd0, 32'h0100_0000);
      clear_all();
      chk_reg("R5 msi cleared", 4'd4, 32'h0);
    end

    // R3 masked MSI vector
    wr(4'd5, 32'h0000_0400);
    @(negedge clk);
    msi_valid = 1'b1; msi_vec = 5'd10; msi_data = 8'hA5;
    @(negedge clk);
    msi_valid = 1'b0;
    chk_reg("R2 masked msi still recorded", 4'd4, 32'h0000_0400);
    chk_reg("R3 masked no pending", 4'd0, 32'h0);
    idle(1);
    chk_reg("R3 masked no host", 4'd7, 32'h0);
    clear_all();
    wr(4'd5, 32'h0);

    // R4 secondary events
    @(negedge clk); pwr_evt = 1'b1;
    @(negedge clk); pwr_evt = 1'b0;
    chk_reg("R4 power bit", 4'd2, 32'h10);
    @(negedge clk); flush_evt = 1'b1;
    @(negedge clk); flush_evt = 1'b0;
    chk_reg("R4 flush bit", 4'd2, 32'h30);
    chk_reg("R8 sec reaches host", 4'd7, 32'h0001_0000);
    clear_all();
    wr(4'd3, 32'h30);
    @(negedge clk); flush_evt = 1'b1;
    @(negedge clk); flush_evt = 1'b0;
    idle(2);
    chk_reg("R7 sec masked no host", 4'd7, 32'h0);
    clear_all();
    wr(4'd3, 32'h0);

    // R6 event and clear on the same edge
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h0004_0000; intx_assert[2] = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; intx_assert = '0;
    chk_reg("R6 intx survives clear", 4'd0, 32'h0004_0000);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd4; reg_wdata = 32'h8000_0000;
    msi_valid = 1'b1; msi_vec = 5'd31; msi_data = 8'h3C;
    @(negedge clk);
    reg_we = 1'b0; msi_valid = 1'b0;
    chk_reg("R6 msi survives clear", 4'd4, 32'h8000_0000);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h20; flush_evt = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; flush_evt = 1'b0;
    chk_reg("R6 sec survives clear", 4'd2, 32'h20);
    clear_all();

    // R9 host mask gates the output
    wr(4'd8, 32'h0001_0000);
    @(negedge clk); pwr_evt = 1'b1;
    @(negedge clk); pwr_evt = 1'b0;
    @(negedge clk);
    chk_reg("R9 host set while masked", 4'd7, 32'h0001_0000);
    chk("R9 masked irq low", {31'b0, irq_out}, 32'h0);
    wr(4'd8, 32'h0);
    chk("R9 unmasked irq high", {31'b0, irq_out}, 32'h1);
    clear_all();
    chk("R9 irq low after clear", {31'b0, irq_out}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule